// File: doc/BRIEF.md
# Lock-Step Phased Bus Bridge (Memory-Side Slave)

This block connects a narrow, byte-wide link between two chips to a local flash-fetch controller. It uses no handshake wires. Both chips run an eight-step phase counter from the same clock and reset, so each side knows which field is on the wires in every cycle. In each eight-cycle frame the slave takes in one request, which carries control flags, an instruction address and a data address. In the same frame it sends back one response, which carries a status byte, an instruction word and a data word.

Once a request frame has been fully received, the slave gives it to the fetch controller as a one-cycle strobe with fields that are held stable. Completion pulses from the fetch controller set sticky ready flags and load word buffers. At the start of the next response frame, the flags are reported and the buffers are snapshotted. The path is read-only: instruction fetches and data loads. No write traffic exists.

Top module: `phased_bridge_slave`

## Requirements
- R1: The phase counter is 0 while reset is asserted, advances by one on every clock and wraps from 7 to 0. The phase-0 byte of each frame is the one present in the cycle right after reset is released, and again every eight cycles after that.
- R2: The request bytes are decoded by phase. Phase 0 is control: bit0 is restart, bit1 is stall, bit2 is the active-low data-read request, and bits 7:3 are ignored. Phases 1 to 3 carry the 24-bit instruction address, least significant byte first. Phases 4 to 6 carry the 24-bit data address, least significant byte first.
- R3: `req_valid` is high for exactly one cycle, in the cycle that follows the clock edge ending phase 7. All request outputs update on that same edge and stay stable until the next strobe.
- R4: The request byte received in phase 7 has no effect on any request output.
- R5: The response byte in phase 0 is the status byte. Bit0 is started, bit1 is stopped, bit2 is instruction-ready, bit3 is data-ready, and bits 7:4 are zero. The started and stopped bits show the fetch-controller levels sampled on the previous clock edge.
- R6: A pulse on `fc_instr_vld` sets the instruction-ready flag, and a pulse on `fc_data_vld` sets the data-ready flag. Each flag stays set until a status byte has reported it, and is cleared on the edge that ends phase 0. A pulse that arrives on that same edge leaves the flag set.
- R7: Phases 1 and 2 carry the 16-bit instruction word and phases 3 to 6 carry the 32-bit data word, each least significant byte first. Both words are taken from a snapshot captured on the edge that ends phase 0. A word that arrives later in the frame does not change the bytes of the current frame.
- R8: The response byte in phase 7 is zero.
- R9: Reset is asynchronous. While it is asserted, `bus_out` is 0, `req_valid`, `req_restart`, `req_stall` and both addresses are 0, `req_data_rd_n` is 1, and all ready flags and word buffers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the far chip |
| rst_n | input | 1 | Active-low reset shared with the far chip, asserted asynchronously, released synchronously |
| bus_in | input | 8 | Request byte from the far chip |
| bus_out | output | 8 | Response byte to the far chip |
| req_valid | output | 1 | One-cycle strobe: new request fields are valid |
| req_restart | output | 1 | Fetch restart request |
| req_stall | output | 1 | Fetch stall request |
| req_data_rd_n | output | 1 | Data read request, active low |
| req_iaddr | output | 24 | Instruction fetch address |
| req_daddr | output | 24 | Data load address |
| fc_started | input | 1 | Fetch controller reports started |
| fc_stopped | input | 1 | Fetch controller reports stopped |
| fc_instr_vld | input | 1 | Pulse: `fc_instr` holds a new instruction word |
| fc_instr | input | 16 | Instruction word from the fetch controller |
| fc_data_vld | input | 1 | Pulse: `fc_data` holds a new data word |
| fc_data | input | 32 | Data word from the fetch controller |

## Verification
The assertions check the following on every cycle:
- the strobe falls in phase 0 and lasts one cycle;
- the request outputs stay stable between strobes;
- the phase-7 response is zero and the upper status bits are zero;
- the ready flags do not drop outside phase 0;
- the word snapshots change only on the edge that ends phase 0.

Only the bench scenarios can show the rest: the byte order of both addresses and both words, that the phase-7 request byte is ignored, that a completion pulse arriving on the clearing edge wins, that words arriving later in a frame do not tear the current frame, and that the frame stays aligned after a reset in the middle of a frame.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int BUS_W      = 8;
  localparam int NPH        = 8;
  localparam int PH_W       = $clog2(NPH);
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = ADDR_BYTES * BUS_W;
  localparam int IW_BYTES   = 2;
  localparam int IW_W       = IW_BYTES * BUS_W;
  localparam int DW_BYTES   = 4;
  localparam int DW_W       = DW_BYTES * BUS_W;

  // request phases
  localparam int PH_CTRL    = 0;
  localparam int PH_IADDR   = 1;
  localparam int PH_DADDR   = PH_IADDR + ADDR_BYTES;
  localparam int PH_LAST    = NPH - 1;
  localparam int SH_BYTES   = 2 * ADDR_BYTES;

  // response phases
  localparam int PH_IWORD   = 1;
  localparam int PH_DWORD   = PH_IWORD + IW_BYTES;

  // control flag bit positions (request phase 0)
  localparam int FLG_RESTART = 0;
  localparam int FLG_STALL   = 1;
  localparam int FLG_RD_N    = 2;

  // status bit positions (response phase 0)
  localparam int ST_STARTED  = 0;
  localparam int ST_STOPPED  = 1;
  localparam int ST_IRDY     = 2;
  localparam int ST_DRDY     = 3;

  typedef logic [PH_W-1:0]  phase_t;
  typedef logic [BUS_W-1:0] byte_t;
endpackage

// File: rtl/pbr_phase_ctr.sv
module pbr_phase_ctr
  import pbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase
);
  phase_t phase_nxt;

  always_comb begin
    if (phase == phase_t'(PH_LAST)) phase_nxt = '0;
    else                            phase_nxt = phase + phase_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_nxt;
  end
endmodule

// File: rtl/pbr_req_deframer.sv
module pbr_req_deframer
  import pbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  byte_t             bus_in,
  output logic              strobe,
  output logic              restart,
  output logic              stall,
  output logic              data_rd_n,
  output logic [ADDR_W-1:0] iaddr,
  output logic [ADDR_W-1:0] daddr
);
  logic [2:0]        flg_q;
  byte_t             sh [SH_BYTES];
  logic [ADDR_W-1:0] iaddr_nxt, daddr_nxt;
  logic              load;

  assign load = (phase == phase_t'(PH_LAST));

  generate
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr
      assign iaddr_nxt[b*BUS_W +: BUS_W] = sh[b];
      assign daddr_nxt[b*BUS_W +: BUS_W] = sh[ADDR_BYTES + b];
    end
  endgenerate

  // shadow capture, one byte per phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= 3'b100;
      for (int i = 0; i < SH_BYTES; i++) sh[i] <= '0;
    end else begin
      if (phase == phase_t'(PH_CTRL))
        flg_q <= {bus_in[FLG_RD_N], bus_in[FLG_STALL], bus_in[FLG_RESTART]};
      for (int i = 0; i < SH_BYTES; i++)
        if (phase == phase_t'(PH_IADDR + i)) sh[i] <= bus_in;
    end
  end

  // presentation registers, loaded once per frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe    <= 1'b0;
      restart   <= 1'b0;
      stall     <= 1'b0;
      data_rd_n <= 1'b1;
      iaddr     <= '0;
      daddr     <= '0;
    end else begin
      strobe <= load;
      if (load) begin
        restart   <= flg_q[0];
        stall     <= flg_q[1];
        data_rd_n <= flg_q[2];
        iaddr     <= iaddr_nxt;
        daddr     <= daddr_nxt;
      end
    end
  end
endmodule

// File: rtl/pbr_rsp_framer.sv
module pbr_rsp_framer
  import pbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  phase_t          phase,
  input  logic            fc_started,
  input  logic            fc_stopped,
  input  logic            fc_instr_vld,
  input  logic [IW_W-1:0] fc_instr,
  input  logic            fc_data_vld,
  input  logic [DW_W-1:0] fc_data,
  output byte_t           bus_out
);
  logic            st_start_q, st_stop_q;
  logic            irdy_q, drdy_q, irdy_nxt, drdy_nxt;
  logic [IW_W-1:0] ibuf_q, ibuf_nxt, isnap_q;
  logic [DW_W-1:0] dbuf_q, dbuf_nxt, dsnap_q;
  logic            at_status;
  byte_t           status;

  assign at_status = (phase == phase_t'(PH_CTRL));

  // next state: a new completion beats the clear of the reporting edge
  always_comb begin
    irdy_nxt = fc_instr_vld ? 1'b1 : (at_status ? 1'b0 : irdy_q);
    drdy_nxt = fc_data_vld  ? 1'b1 : (at_status ? 1'b0 : drdy_q);
    ibuf_nxt = fc_instr_vld ? fc_instr : ibuf_q;
    dbuf_nxt = fc_data_vld  ? fc_data  : dbuf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_start_q <= 1'b0;
      st_stop_q  <= 1'b0;
      irdy_q     <= 1'b0;
      drdy_q     <= 1'b0;
      ibuf_q     <= '0;
      dbuf_q     <= '0;
      isnap_q    <= '0;
      dsnap_q    <= '0;
    end else begin
      st_start_q <= fc_started;
      st_stop_q  <= fc_stopped;
      irdy_q     <= irdy_nxt;
      drdy_q     <= drdy_nxt;
      ibuf_q     <= ibuf_nxt;
      dbuf_q     <= dbuf_nxt;
      if (at_status) begin
        isnap_q <= ibuf_q;
        dsnap_q <= dbuf_q;
      end
    end
  end

  always_comb begin
    status             = '0;
    status[ST_STARTED] = st_start_q;
    status[ST_STOPPED] = st_stop_q;
    status[ST_IRDY]    = irdy_q;
    status[ST_DRDY]    = drdy_q;
  end

  always_comb begin
    bus_out = '0;
    if (at_status) bus_out = status;
    for (int b = 0; b < IW_BYTES; b++)
      if (phase == phase_t'(PH_IWORD + b)) bus_out = isnap_q[b*BUS_W +: BUS_W];
    for (int b = 0; b < DW_BYTES; b++)
      if (phase == phase_t'(PH_DWORD + b)) bus_out = dsnap_q[b*BUS_W +: BUS_W];
  end

  // R6: a ready flag only drops on the edge that ends the status phase
  a_r6_irdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irdy_q) && ($past(phase) != phase_t'(PH_CTRL))) |-> irdy_q);
  a_r6_drdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drdy_q) && ($past(phase) != phase_t'(PH_CTRL))) |-> drdy_q);
  // R7: the word snapshots stay frozen through the rest of the frame
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) != phase_t'(PH_CTRL)) |-> ($stable(isnap_q) && $stable(dsnap_q)));
endmodule

// File: rtl/phased_bridge_slave.sv
module phased_bridge_slave
  import pbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              req_valid,
  output logic              req_restart,
  output logic              req_stall,
  output logic              req_data_rd_n,
  output logic [ADDR_W-1:0] req_iaddr,
  output logic [ADDR_W-1:0] req_daddr,
  input  logic              fc_started,
  input  logic              fc_stopped,
  input  logic              fc_instr_vld,
  input  logic [IW_W-1:0]   fc_instr,
  input  logic              fc_data_vld,
  input  logic [DW_W-1:0]   fc_data
);
  phase_t phase;

  pbr_phase_ctr u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  pbr_req_deframer u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .bus_in    (bus_in),
    .strobe    (req_valid),
    .restart   (req_restart),
    .stall     (req_stall),
    .data_rd_n (req_data_rd_n),
    .iaddr     (req_iaddr),
    .daddr     (req_daddr)
  );

  pbr_rsp_framer u_rsp (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .fc_started   (fc_started),
    .fc_stopped   (fc_stopped),
    .fc_instr_vld (fc_instr_vld),
    .fc_instr     (fc_instr),
    .fc_data_vld  (fc_data_vld),
    .fc_data      (fc_data),
    .bus_out      (bus_out)
  );

  // R3: the strobe falls in the first phase of a frame and lasts one cycle
  a_r3_strobe_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (phase == phase_t'(PH_CTRL)));
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ($stable(req_iaddr) && $stable(req_daddr) && $stable(req_restart)
                    && $stable(req_stall) && $stable(req_data_rd_n)));
  // R8: the last response phase carries nothing
  a_r8_last_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == phase_t'(PH_LAST)) |-> (bus_out == '0));
  // R5: the unused upper status bits stay low
  a_r5_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == phase_t'(PH_CTRL)) |-> (bus_out[BUS_W-1:4] == '0));
endmodule

// File: tb/phased_bridge_slave_test.sv
module phased_bridge_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {phase7 byte, daddr, iaddr, ctrl}
  localparam logic [63:0] VEC [NVEC] = '{
    64'hFF_123456_ABCDEF_01,
    64'h00_000000_000000_04,
    64'h5A_FFFFFF_FFFFFF_FA,
    64'h00_0000FF_FF0000_07,
    64'hA5_123456_ABCDEF_01
  };

  logic        clk, rst_n;
  logic [7:0]  bus_in, bus_out;
  logic        req_valid, req_restart, req_stall, req_data_rd_n;
  logic [23:0] req_iaddr, req_daddr;
  logic        fc_started, fc_stopped, fc_instr_vld, fc_data_vld;
  logic [15:0] fc_instr;
  logic [31:0] fc_data;

  int checks = 0;
  int errors = 0;
  logic [7:0]  rx [8];
  logic        vld_seen [8];
  logic [23:0] mid_iaddr;

  phased_bridge_slave uut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .req_valid(req_valid), .req_restart(req_restart), .req_stall(req_stall),
    .req_data_rd_n(req_data_rd_n), .req_iaddr(req_iaddr), .req_daddr(req_daddr),
    .fc_started(fc_started), .fc_stopped(fc_stopped),
    .fc_instr_vld(fc_instr_vld), .fc_instr(fc_instr),
    .fc_data_vld(fc_data_vld), .fc_data(fc_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame, starting at the negedge inside phase 0.
  task automatic run_frame(input logic [63:0] req, input int ip, input logic [15:0] iw,
                           input int dp, input logic [31:0] dw, input logic set_st,
                           input logic st_v, input logic sp_v);
    for (int p = 0; p < 8; p++) begin
      bus_in       = req[p*8 +: 8];
      fc_instr_vld = (p == ip);
      if (p == ip) fc_instr = iw;
      fc_data_vld  = (p == dp);
      if (p == dp) fc_data = dw;
      if (set_st && p == 1) begin
        fc_started = st_v;
        fc_stopped = sp_v;
      end
      rx[p]       = bus_out;
      vld_seen[p] = req_valid;
      if (p == 6) mid_iaddr = req_iaddr;
      @(posedge clk);
      @(negedge clk);
    end
    fc_instr_vld = 1'b0;
    fc_data_vld  = 1'b0;
  endtask

  task automatic chk_fields(input logic [63:0] v, input string tag);
    chk(req_valid == 1'b1, {tag, " R3 strobe"}, 64'(req_valid), 64'd1);
    chk({req_data_rd_n, req_stall, req_restart} == v[2:0], {tag, " R2 flags"},
        64'({req_data_rd_n, req_stall, req_restart}), 64'(v[2:0]));
    chk(req_iaddr == v[31:8], {tag, " R2 iaddr"}, 64'(req_iaddr), 64'(v[31:8]));
    chk(req_daddr == v[55:32], {tag, " R2 daddr"}, 64'(req_daddr), 64'(v[55:32]));
  endtask

  task automatic chk_rsp(input logic [7:0] st, input logic [15:0] iw,
                         input logic [31:0] dw, input string tag);
    chk(rx[0] == st, {tag, " R5 R6 status"}, 64'(rx[0]), 64'(st));
    chk({rx[2], rx[1]} == iw, {tag, " R7 iword"}, 64'({rx[2], rx[1]}), 64'(iw));
    chk({rx[6], rx[5], rx[4], rx[3]} == dw, {tag, " R7 dword"},
        64'({rx[6], rx[5], rx[4], rx[3]}), 64'(dw));
    chk(rx[7] == 8'h00, {tag, " R8 last"}, 64'(rx[7]), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_in = '0;
    fc_started = 1'b0; fc_stopped = 1'b0;
    fc_instr_vld = 1'b0; fc_data_vld = 1'b0; fc_instr = '0; fc_data = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(bus_out == 8'h00, "R9 bus_out", 64'(bus_out), 64'd0);
    chk({req_valid, req_restart, req_stall, req_data_rd_n} == 4'b0001, "R9 req flags",
        64'({req_valid, req_restart, req_stall, req_data_rd_n}), 64'd1);
    chk(req_iaddr == '0 && req_daddr == '0, "R9 addresses",
        64'({req_iaddr, req_daddr}), 64'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R8: table walk, frames back to back
    for (int k = 0; k < NVEC; k++) begin
      run_frame(VEC[k], -1, '0, -1, '0, 1'b0, 1'b0, 1'b0);
      chk(vld_seen[1:7] == '{7{1'b0}}, "R3 no strobe inside frame", 64'd1, 64'd0);
      chk(rx[7] == 8'h00, "R8 phase 7 zero", 64'(rx[7]), 64'd0);
      if (k > 0)
        chk(mid_iaddr == VEC[k-1][31:8], "R3 hold between strobes",
            64'(mid_iaddr), 64'(VEC[k-1][31:8]));
      chk_fields(VEC[k], $sformatf("vec%0d R1", k));
    end

    // R5 R6 R7: response scenario
    run_frame(VEC[0], 3, 16'h1234, 5, 32'hCAFEF00D, 1'b1, 1'b1, 1'b0);
    chk(rx[0] == 8'h00, "frameA R5 status", 64'(rx[0]), 64'd0);
    // frame B: instr pulse on the clearing edge, data pulse mid-frame
    run_frame(VEC[1], 0, 16'hBEEF, 4, 32'h11223344, 1'b0, 1'b0, 1'b0);
    chk_rsp(8'h0D, 16'h1234, 32'hCAFEF00D, "frameB");
    run_frame(VEC[2], -1, '0, -1, '0, 1'b1, 1'b0, 1'b1);
    chk_rsp(8'h0D, 16'hBEEF, 32'h11223344, "frameC");
    run_frame(VEC[3], -1, '0, -1, '0, 1'b0, 1'b0, 1'b0);
    chk(rx[0] == 8'h02, "frameD R6 flags cleared, R5 stopped", 64'(rx[0]), 64'h02);
    chk_fields(VEC[3], "frameD");

    // R9 R1: asynchronous reset in mid-frame, then realignment
    fc_instr_vld = 1'b1; fc_instr = 16'h7777;
    @(posedge clk); @(negedge clk);
    fc_instr_vld = 1'b0;
    @(posedge clk); @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(bus_out == 8'h00 && req_iaddr == '0 && req_data_rd_n == 1'b1,
        "R9 async reset", 64'({bus_out, req_iaddr, req_data_rd_n}), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(VEC[2], -1, '0, -1, '0, 1'b0, 1'b0, 1'b0);
    chk(rx[0] == 8'h00, "R9 flags cleared by reset", 64'(rx[0]), 64'd0);
    chk(vld_seen[0] == 1'b0, "R9 no strobe after reset", 64'(vld_seen[0]), 64'd0);
    chk_fields(VEC[2], "after reset R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule